// File: doc/BRIEF.md
# Radix-4 Recoded Signed Multiplier

This block multiplies two N-bit two's-complement numbers and returns the full 2N-bit signed product with no clock and no internal state. The multiplier operand is read in overlapping three-bit windows, one per pair of bits. Each window is recoded into a signed digit between -2 and +2. This gives N/2 partial-product rows instead of N, and every row is a simple multiple of the multiplicand: zero, single or double, possibly negated. No row ever needs a triple multiple.

Each row is formed by a small selector. A negative multiple is made by inverting the bits and adding a one at the row's lowest column. The sign extension of every row is replaced by flipping its sign bit and adding a single precomputed constant. The rows, the constant and the negation ones are reduced in carry-save form by a chain of 3:2 compressors. One carry-propagate adder then turns the redundant pair into the product. The block fits into any datapath that needs a combinational signed multiply. The operand width N must be even.

Top module: `booth_mul`

## Requirements
- R1: For every pair of N-bit two's-complement operands, `product` equals their exact signed product as a 2N-bit two's-complement number.
- R2: Row i takes multiplier bits 2i+1, 2i and 2i-1, with bit -1 read as 0. Its digit is -2·b(2i+1) + b(2i) + b(2i-1), so the value lies in {-2,-1,0,+1,+2}.
- R3: In every row, at most one of the single and double selects is active. A row whose digit is zero, including the window 111, asserts no negation.
- R4: A negative digit yields the bitwise inverse of the selected multiple plus a one injected at column 2i. Digits -1 and -2 therefore give exact products, for example multiplier all ones (-1) and multiplier 0x80 in the top row.
- R5: Sign extension uses an inverted row sign bit plus one constant equal to minus the sum of 2^(N+2i) over all rows, taken modulo 2^(2N). Products with negative multiplicands and mixed-sign rows come out exact.
- R6: The carry-save sum and carry vectors, added modulo 2^(2N), already equal the final product before the carry-propagate adder.
- R7: If either operand is zero, the product is zero whatever the other operand holds.
- R8: The most negative operand times itself, (-2^(N-1))², gives the positive value 2^(2N-2) without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | N | Multiplicand, two's complement |
| mplier | input | N | Multiplier, two's complement, recoded in bit pairs |
| product | output | 2N | Signed product, two's complement |

## Verification
The hardest case to reach is a multiplier whose windows mix the digits -2, -1 and zero (window 111) across rows while the multiplicand is at its negative extreme. Only that combination puts the sign-correction constant, the injected negation ones and the inverted sign bits into the same columns at once. The vector table targets these patterns directly, for example 0x80, 0xAA and 0xFF paired with -128 and 127. An exhaustive sweep of all operand pairs at the default width then covers every digit combination in every row.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef struct packed {
    logic one;
    logic two;
    logic neg;
  } booth_sel_t;

  // Recode a window {b(2i+1), b(2i), b(2i-1)} into select lines
  function automatic booth_sel_t booth_decode(input logic [2:0] win);
    booth_sel_t s;
    s.one = win[1] ^ win[0];
    s.two = (win[2] & ~win[1] & ~win[0]) | (~win[2] & win[1] & win[0]);
    s.neg = win[2] & ~(win[1] & win[0]);
    return s;
  endfunction

  function automatic logic xor3(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/booth_enc.sv
module booth_enc
  import booth_pkg::*;
(
  input  logic [2:0]  win,
  output booth_sel_t  sel
);
  assign sel = booth_decode(win);
endmodule

// File: rtl/booth_row.sv
module booth_row
  import booth_pkg::*;
#(
  parameter int N   = 8,
  parameter int OFS = 0
) (
  input  logic [N-1:0]   mcand,
  input  booth_sel_t     sel,
  output logic [2*N-1:0] row_bits
);
  localparam int W = 2 * N;

  logic [N:0] mult;
  logic [N:0] pp;

  always_comb begin
    if (sel.one)      mult = {mcand[N-1], mcand};
    else if (sel.two) mult = {mcand, 1'b0};
    else              mult = '0;
    pp = mult ^ {(N+1){sel.neg}};
  end

  // Sign bit inverted; the constant row restores the true value
  assign row_bits = W'({{(W-N-1){1'b0}}, ~pp[N], pp[N-1:0]} << OFS);
endmodule

// File: rtl/booth_csa_array.sv
module booth_csa_array
  import booth_pkg::*;
#(
  parameter int W = 16,
  parameter int R = 5
) (
  input  logic [R-1:0][W-1:0] rows,
  output logic [W-1:0]        sum_o,
  output logic [W-1:0]        carry_o
);
  localparam int STAGES = R - 1;

  logic [STAGES-1:0][W-1:0] s_st;
  logic [STAGES-1:0][W-1:0] c_st;

  assign s_st[0] = rows[0];
  assign c_st[0] = rows[1];

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    for (genvar b = 0; b < W; b++) begin : g_bit
      assign s_st[k][b] = xor3(s_st[k-1][b], c_st[k-1][b], rows[k+1][b]);
      if (b < W - 1) begin : g_cy
        assign c_st[k][b+1] = maj3(s_st[k-1][b], c_st[k-1][b], rows[k+1][b]);
      end
    end
    assign c_st[k][0] = 1'b0;
  end

  assign sum_o   = s_st[STAGES-1];
  assign carry_o = c_st[STAGES-1];
endmodule

// File: rtl/booth_cpa.sv
module booth_cpa
  import booth_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);
  logic [W-1:0] cy;

  assign cy[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i] = xor3(a[i], b[i], cy[i]);
    if (i < W - 1) begin : g_cy
      assign cy[i+1] = maj3(a[i], b[i], cy[i]);
    end
  end
endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic [2*N-1:0] product
);
  localparam int W = 2 * N;
  localparam int M = N / 2;
  localparam int R = M + 1;

  function automatic logic [W-1:0] sext_const();
    logic [W-1:0] acc;
    acc = '0;
    for (int i = 0; i < M; i++) acc = acc - (W'(1) << (N + 2 * i));
    return acc;
  endfunction

  localparam logic [W-1:0] SEXT_K = sext_const();

  logic [N:0]          mp_ext;
  logic [M-1:0]        sel_one;
  logic [M-1:0]        sel_two;
  logic [M-1:0]        sel_neg;
  logic [W-1:0]        neg_cols;
  logic [R-1:0][W-1:0] rows;
  logic [W-1:0]        red_sum;
  logic [W-1:0]        red_carry;

  assign mp_ext = {mplier, 1'b0};

  for (genvar i = 0; i < M; i++) begin : g_row
    booth_sel_t sel;
    booth_enc u_enc (
      .win (mp_ext[2*i+2 -: 3]),
      .sel (sel)
    );
    booth_row #(.N(N), .OFS(2*i)) u_row (
      .mcand    (mcand),
      .sel      (sel),
      .row_bits (rows[i])
    );
    assign sel_one[i] = sel.one;
    assign sel_two[i] = sel.two;
    assign sel_neg[i] = sel.neg;
  end

  always_comb begin
    neg_cols = '0;
    for (int i = 0; i < M; i++) neg_cols[2*i] = sel_neg[i];
  end

  // Constant occupies columns >= N, negation ones columns < N
  assign rows[M] = SEXT_K | neg_cols;

  booth_csa_array #(.W(W), .R(R)) u_csa (
    .rows    (rows),
    .sum_o   (red_sum),
    .carry_o (red_carry)
  );

  booth_cpa #(.W(W)) u_cpa (
    .a (red_sum),
    .b (red_carry),
    .s (product)
  );
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int N = 8
) (
  input logic [N-1:0]   mcand,
  input logic [N-1:0]   mplier,
  input logic [2*N-1:0] product,
  input logic [N/2-1:0] sel_one,
  input logic [N/2-1:0] sel_two,
  input logic [N/2-1:0] sel_neg,
  input logic [2*N-1:0] red_sum,
  input logic [2*N-1:0] red_carry
);
  localparam int W = 2 * N;
  localparam int M = N / 2;

  logic [W-1:0] a_ext;
  logic [W-1:0] b_ext;
  logic [W-1:0] ref_p;
  logic [N:0]   mp_ext;

  assign a_ext  = {{N{mcand[N-1]}}, mcand};
  assign b_ext  = {{N{mplier[N-1]}}, mplier};
  assign ref_p  = a_ext * b_ext;
  assign mp_ext = {mplier, 1'b0};

  function automatic int win_digit(input logic [2:0] w);
    return -2 * int'(w[2]) + int'(w[1]) + int'(w[0]);
  endfunction

  function automatic int sel_digit(input logic one, input logic two, input logic neg);
    int mag;
    mag = two ? 2 : (one ? 1 : 0);
    return neg ? -mag : mag;
  endfunction

  always_comb begin
    if (!$isunknown({mcand, mplier})) begin
      assert_product_R1: assert (product == ref_p)
        else $error("R1 product %h expected %h", product, ref_p);
      assert_redundant_R6: assert (W'(red_sum + red_carry) == ref_p)
        else $error("R6 carry-save pair does not sum to product");
      assert_zero_R7: assert (!(mcand == '0 || mplier == '0) || product == '0)
        else $error("R7 zero operand gave nonzero product");
      for (int i = 0; i < M; i++) begin
        assert_digit_R2: assert (win_digit(mp_ext[2*i+2 -: 3]) ==
                                 sel_digit(sel_one[i], sel_two[i], sel_neg[i]))
          else $error("R2 row %0d digit mismatch", i);
        assert_select_R3: assert (!(sel_one[i] && sel_two[i]) &&
                                  (!sel_neg[i] || sel_one[i] || sel_two[i]))
          else $error("R3 row %0d select lines inconsistent", i);
      end
    end
  end
endmodule

bind booth_mul booth_mul_chk #(.N(N)) u_chk (
  .mcand     (mcand),
  .mplier    (mplier),
  .product   (product),
  .sel_one   (sel_one),
  .sel_two   (sel_two),
  .sel_neg   (sel_neg),
  .red_sum   (red_sum),
  .red_carry (red_carry)
);

// File: tb/booth_mul_tb_top.sv
module booth_mul_tb_top;
  localparam int N  = 8;
  localparam int W  = 2 * N;
  localparam int NV = 14;

  // {mcand, mplier, expected product}
  localparam logic [31:0] VEC [NV] = '{
    {8'h00, 8'h00, 16'h0000},  // R7
    {8'h01, 8'h01, 16'h0001},  // R1
    {8'hFF, 8'hFF, 16'h0001},  // R4 digit -1 rows
    {8'h80, 8'h80, 16'h4000},  // R8
    {8'h80, 8'h7F, 16'hC080},  // R5
    {8'h7F, 8'h7F, 16'h3F01},  // R1
    {8'h7F, 8'h80, 16'hC080},  // R4 digit -2 top row
    {8'h03, 8'h05, 16'h000F},  // R2
    {8'hFD, 8'h05, 16'hFFF1},  // R5
    {8'h55, 8'hAA, 16'hE372},  // R2 mixed digits
    {8'h01, 8'hAA, 16'hFFAA},  // R4
    {8'h80, 8'h01, 16'hFF80},  // R5
    {8'h80, 8'h02, 16'hFF00},  // R3 double select
    {8'h5A, 8'h00, 16'h0000}   // R7
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] mcand = '0;
  logic [N-1:0] mplier = '0;
  logic [W-1:0] product;
  int           n_chk = 0;
  int           n_bad = 0;
  int           cyc = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  booth_mul #(.N(N)) dut_i (
    .mcand   (mcand),
    .mplier  (mplier),
    .product (product)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run did not complete, actual cycles %0d expected < 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b,
                       input logic [W-1:0] exp, input string tag);
    @(posedge clk);
    mcand  = a;
    mplier = b;
    @(negedge clk);
    n_chk = n_chk + 1;
    if (product !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: %h * %h actual %h expected %h", tag, a, b, product, exp);
    end
  endtask

  initial begin
    // Reset phase: operands held at zero, product must be zero (R7)
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk = n_chk + 1;
    if (product !== '0) begin
      n_bad = n_bad + 1;
      $display("FAIL R7 reset: actual %h expected 0000", product);
    end
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][31:24], VEC[i][23:16], VEC[i][15:0], "R1/table");
    end

    // Directed corner cases
    apply(8'h80, 8'h80, 16'h4000, "R8");
    apply(8'h00, 8'h80, 16'h0000, "R7");
    apply(8'hFF, 8'h80, 16'h0080, "R4");
    apply(8'h80, 8'hFF, 16'h0080, "R5");
    apply(8'h7F, 8'h07, 16'h0379, "R3");
    apply(8'h40, 8'h06, 16'h0180, "R2");
    apply(8'hC0, 8'h06, 16'hFE80, "R6");

    // Exhaustive sweep against a signed integer multiply
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        int sa;
        int sb;
        sa = (a >= 128) ? a - 256 : a;
        sb = (b >= 128) ? b - 256 : b;
        apply(N'(a), N'(b), W'(sa * sb), "R1");
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule